// File: doc/BRIEF.md
# Handheld System Power Sequencer

This controller decides when a battery-powered handheld may switch its main supply rails on and off. It watches a user on-button, a power-good level from the system supply and the supply's status interrupt line. It also accepts a wake request from the interrupt logic. It drives one chip-select towards the supply: high means the main rails are on. It tracks the operating mode as off (after power-on reset), running, dozing or sleeping.

Software reaches the controller through a small register port. A command register requests sleep or doze. A status register holds two sticky flags, which software clears by writing ones to them. An enable register masks the two interrupt lines to the CPU. The high-priority emergency line reports that power-good fell while the rails were on. The low-priority line reports that the supply wants its status read. The three asynchronous inputs pass through two-flop synchronizers. Only the rising edge of the on-button has an effect.

Top module: `pwr_sequencer`

## Requirements
- R1: After reset the mode output is 00 (off), the chip-select is low, both interrupt outputs are low, the status flags read 0 and the interrupt enable register reads 2'b11.
- R2: In the off mode only a rising edge of the on-button, with power-good high, moves to running (mode 01) and raises the chip-select; a wake request in the off mode has no effect.
- R3: The chip-select never rises while the synchronized power-good is low; an on-button edge or a wake request at that time leaves the mode unchanged.
- R4: In the sleep mode (11), with power-good high, either an on-button rising edge or a wake request returns to running and raises the chip-select.
- R5: A write to address 0 with bit 0 set, in running or dozing, enters sleep and drops the chip-select. With bit 1 set and bit 0 clear, in running, the write enters dozing (10) and the chip-select stays high. When both bits are set, sleep wins.
- R6: Dozing returns to running on a wake request or on an asserted (enabled) interrupt output; a flag whose interrupt is masked does not end dozing.
- R7: A falling edge of power-good while in running or dozing sets status bit 0 (emergency); the emergency output equals status bit 0 AND enable bit 0, and the mode stays as it was.
- R8: A rising edge of the supply status line sets status bit 1; the low-priority output equals status bit 1 AND enable bit 1, and this event never sets the emergency flag.
- R9: Writing to address 1 clears each status flag whose data bit is 1 and leaves the flags whose data bit is 0.
- R10: With the read strobe high, address 1 returns {0.., mode[1:0], flag1, flag0} and address 2 returns the enable bits in bits 1:0 (written at address 2); with the read strobe low the read data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset (power-on reset) |
| onButton | input | 1 | User on-button, asynchronous |
| powerGood | input | 1 | Supply power-good level, asynchronous |
| supplyIrq | input | 1 | Supply status interrupt line, asynchronous |
| wakeReq | input | 1 | Synchronous wake request from interrupt logic |
| regWrite | input | 1 | Register write strobe |
| regRead | input | 1 | Register read strobe |
| regAddr | input | ADDR_W | Register address |
| regWdata | input | DATA_W | Register write data |
| regRdata | output | DATA_W | Register read data |
| supplyCs | output | 1 | Supply chip-select, high turns main rails on |
| mode | output | 2 | Operating mode: 00 off, 01 run, 10 doze, 11 sleep |
| emergIrq | output | 1 | High-priority power-loss interrupt |
| statIrq | output | 1 | Low-priority supply status interrupt |

## Verification
The hardest case to reach is dozing with a flag set but masked, where the controller must stay put. Nothing at the ports changes then except the status readback. The bench clears enable bit 1 through the register port, enters doze, and pulses the supply line long enough to clear the synchronizer. It then checks that the mode still reads doze, that the flag is visible in the status register, and that a later wake request ends the doze. Power-good loss is driven while running, so the emergency edge is seen only once.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;
  typedef enum logic [1:0] {
    MODE_OFF   = 2'b00,
    MODE_RUN   = 2'b01,
    MODE_DOZE  = 2'b10,
    MODE_SLEEP = 2'b11
  } pwr_mode_e;

  typedef struct packed {
    logic setEmerg;
    logic setStat;
  } flag_strobe_t;

  typedef struct packed {
    logic goSleep;
    logic goDoze;
  } cmd_strobe_t;

  localparam int ADDR_CMD    = 0;
  localparam int ADDR_STATUS = 1;
  localparam int ADDR_IRQEN  = 2;
  localparam int FLAG_EMERG  = 0;
  localparam int FLAG_STAT   = 1;
endpackage

// File: rtl/pwrseq_sync.sv
module pwrseq_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '0;
      else       chain <= {chain[STAGES-2:0], asyncIn[b]};
    end
    assign syncOut[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/pwrseq_ctrl.sv
module pwrseq_ctrl
  import pwrseq_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         btnSync,
  input  logic         pgSync,
  input  logic         supSync,
  input  logic         wakeReq,
  input  cmd_strobe_t  cmd,
  input  logic         irqPending,
  output pwr_mode_e    modeQ,
  output logic         csQ,
  output flag_strobe_t strobe
);
  logic btnPrev, pgPrev, supPrev;
  logic btnRise, pgFall, supRise;
  logic railsOn;
  pwr_mode_e modeNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      btnPrev <= 1'b0;
      pgPrev  <= 1'b0;
      supPrev <= 1'b0;
    end else begin
      btnPrev <= btnSync;
      pgPrev  <= pgSync;
      supPrev <= supSync;
    end
  end

  assign btnRise = btnSync & ~btnPrev;
  assign pgFall  = pgPrev & ~pgSync;
  assign supRise = supSync & ~supPrev;
  assign railsOn = (modeQ == MODE_RUN) || (modeQ == MODE_DOZE);

  always_comb begin
    modeNext = modeQ;
    unique case (modeQ)
      MODE_OFF:   if (btnRise && pgSync) modeNext = MODE_RUN;
      MODE_SLEEP: if ((btnRise || wakeReq) && pgSync) modeNext = MODE_RUN;
      MODE_RUN: begin
        if (cmd.goSleep)     modeNext = MODE_SLEEP;
        else if (cmd.goDoze) modeNext = MODE_DOZE;
      end
      MODE_DOZE: begin
        if (cmd.goSleep)                 modeNext = MODE_SLEEP;
        else if (wakeReq || irqPending)  modeNext = MODE_RUN;
      end
      default: modeNext = MODE_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= MODE_OFF;
      csQ   <= 1'b0;
    end else begin
      modeQ <= modeNext;
      csQ   <= (modeNext == MODE_RUN) || (modeNext == MODE_DOZE);
    end
  end

  assign strobe.setEmerg = pgFall & railsOn;
  assign strobe.setStat  = supRise;

  AST_CS_NEEDS_PG: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csQ) |-> $past(pgSync)); // R3
  AST_OFF_BUTTON_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_OFF && !btnRise) |=> (modeQ == MODE_OFF)); // R2
  AST_CS_LOW_WHEN_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_SLEEP || modeQ == MODE_OFF) |-> !csQ); // R5
  AST_SLEEP_CMD: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.goSleep && railsOn) |=> (modeQ == MODE_SLEEP)); // R5
endmodule

// File: rtl/pwrseq_regs.sv
module pwrseq_regs
  import pwrseq_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrite,
  input  logic              regRead,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  input  flag_strobe_t      strobe,
  input  pwr_mode_e         modeQ,
  output cmd_strobe_t       cmd,
  output logic [DATA_W-1:0] regRdata,
  output logic              emergIrq,
  output logic              statIrq
);
  localparam int PAD_W = DATA_W - 4;

  logic [1:0] flags, irqEn, clearMask, setMask;
  logic selCmd, selStatus, selIrqEn;

  assign selCmd    = regAddr == ADDR_W'(ADDR_CMD);
  assign selStatus = regAddr == ADDR_W'(ADDR_STATUS);
  assign selIrqEn  = regAddr == ADDR_W'(ADDR_IRQEN);

  assign cmd.goSleep = regWrite && selCmd && regWdata[0];
  assign cmd.goDoze  = regWrite && selCmd && regWdata[1] && !regWdata[0];

  assign clearMask = (regWrite && selStatus) ? regWdata[1:0] : 2'b00;
  assign setMask[FLAG_EMERG] = strobe.setEmerg;
  assign setMask[FLAG_STAT]  = strobe.setStat;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flags <= 2'b00;
      irqEn <= 2'b11;
    end else begin
      flags <= (flags & ~clearMask) | setMask;
      if (regWrite && selIrqEn) irqEn <= regWdata[1:0];
    end
  end

  assign emergIrq = flags[FLAG_EMERG] & irqEn[FLAG_EMERG];
  assign statIrq  = flags[FLAG_STAT]  & irqEn[FLAG_STAT];

  always_comb begin
    regRdata = '0;
    if (regRead) begin
      if (selStatus)     regRdata = {{PAD_W{1'b0}}, modeQ, flags};
      else if (selIrqEn) regRdata = {{(DATA_W-2){1'b0}}, irqEn};
    end
  end

  AST_EMERG_LATCHES: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setEmerg |=> flags[FLAG_EMERG]); // R7
  AST_STAT_LATCHES: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setStat |=> flags[FLAG_STAT]); // R8
  AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (flags[FLAG_STAT] && !clearMask[FLAG_STAT]) |=> flags[FLAG_STAT]); // R9
  AST_EMERG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (flags[FLAG_EMERG] && !clearMask[FLAG_EMERG]) |=> flags[FLAG_EMERG]); // R9
endmodule

// File: rtl/pwr_sequencer.sv
module pwr_sequencer
  import pwrseq_pkg::*;
#(
  parameter int ADDR_W      = 2,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              onButton,
  input  logic              powerGood,
  input  logic              supplyIrq,
  input  logic              wakeReq,
  input  logic              regWrite,
  input  logic              regRead,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              supplyCs,
  output logic [1:0]        mode,
  output logic              emergIrq,
  output logic              statIrq
);
  localparam int N_ASYNC = 3;

  logic [N_ASYNC-1:0] syncBits;
  flag_strobe_t strobe;
  cmd_strobe_t  cmd;
  pwr_mode_e    modeQ;

  pwrseq_sync #(.WIDTH(N_ASYNC), .STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN),
    .asyncIn({supplyIrq, powerGood, onButton}),
    .syncOut(syncBits)
  );

  pwrseq_ctrl uCtrl (
    .clk(clk), .rstN(rstN),
    .btnSync(syncBits[0]), .pgSync(syncBits[1]), .supSync(syncBits[2]),
    .wakeReq(wakeReq), .cmd(cmd), .irqPending(emergIrq | statIrq),
    .modeQ(modeQ), .csQ(supplyCs), .strobe(strobe)
  );

  pwrseq_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uRegs (
    .clk(clk), .rstN(rstN),
    .regWrite(regWrite), .regRead(regRead), .regAddr(regAddr),
    .regWdata(regWdata), .strobe(strobe), .modeQ(modeQ),
    .cmd(cmd), .regRdata(regRdata), .emergIrq(emergIrq), .statIrq(statIrq)
  );

  assign mode = modeQ;
endmodule

// File: tb/pwr_sequencer_test.sv
module pwr_sequencer_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic onButton = 1'b0, powerGood = 1'b0, supplyIrq = 1'b0, wakeReq = 1'b0;
  logic regWrite = 1'b0, regRead = 1'b0;
  logic [1:0] regAddr = '0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic supplyCs, emergIrq, statIrq;
  logic [1:0] mode;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pwr_sequencer uut (
    .clk(clk), .rstN(rstN), .onButton(onButton), .powerGood(powerGood),
    .supplyIrq(supplyIrq), .wakeReq(wakeReq), .regWrite(regWrite),
    .regRead(regRead), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .supplyCs(supplyCs), .mode(mode),
    .emergIrq(emergIrq), .statIrq(statIrq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrite = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWrite = 1'b0; regWdata = '0;
    idle(1);
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    regRead = 1'b1; regAddr = a;
    #1 d = regRdata;
    regRead = 1'b0;
  endtask

  task automatic pressButton();
    @(negedge clk); onButton = 1'b1;
    idle(6);
    onButton = 1'b0;
    idle(4);
  endtask

  task automatic pulseSupply();
    @(negedge clk); supplyIrq = 1'b1;
    idle(4);
    supplyIrq = 1'b0;
    idle(5);
  endtask

  task automatic pulseWake();
    @(negedge clk); wakeReq = 1'b1;
    @(negedge clk); wakeReq = 1'b0;
    idle(2);
  endtask

  task automatic setPg(input logic v);
    @(negedge clk); powerGood = v;
    idle(6);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 mode", {6'b0, mode}, 8'h00);
    chk("R1 cs", {7'b0, supplyCs}, 8'h00);
    chk("R1 irqs", {6'b0, emergIrq, statIrq}, 8'h00);
    rd(2'd1, d); chk("R1 status", d, 8'h00);
    rd(2'd2, d); chk("R1 enable", d, 8'h03);
  endtask

  task automatic t_off_paths();
    setPg(1'b1);
    pulseWake();
    chk("R2 wake ignored in off", {6'b0, mode}, 8'h00);
    chk("R2 cs stays low", {7'b0, supplyCs}, 8'h00);
    setPg(1'b0);
    pressButton();
    chk("R3 button with pg low", {7'b0, supplyCs}, 8'h00);
    chk("R3 mode off", {6'b0, mode}, 8'h00);
    setPg(1'b1);
    pressButton();
    chk("R2 button powers on mode", {6'b0, mode}, 8'h01);
    chk("R2 button powers on cs", {7'b0, supplyCs}, 8'h01);
  endtask

  task automatic t_supply_irq();
    logic [7:0] d;
    pulseSupply();
    chk("R8 statIrq", {7'b0, statIrq}, 8'h01);
    chk("R8 no emergency", {7'b0, emergIrq}, 8'h00);
    rd(2'd1, d); chk("R10 status read", d, 8'h06);
    rd(2'd3, d); chk("R10 unused address", d, 8'h00);
    wr(2'd1, 8'h02);
    chk("R9 W1C clears statIrq", {7'b0, statIrq}, 8'h00);
    rd(2'd1, d); chk("R9 status after clear", d, 8'h04);
  endtask

  task automatic t_doze();
    wr(2'd0, 8'h02);
    chk("R5 doze mode", {6'b0, mode}, 8'h02);
    chk("R5 doze cs high", {7'b0, supplyCs}, 8'h01);
    pulseSupply();
    chk("R6 enabled irq wakes", {6'b0, mode}, 8'h01);
    wr(2'd1, 8'h02);
  endtask

  task automatic t_masked_doze();
    logic [7:0] d;
    wr(2'd2, 8'h01);
    rd(2'd2, d); chk("R10 enable read", d, 8'h01);
    wr(2'd0, 8'h02);
    pulseSupply();
    chk("R6 masked flag keeps doze", {6'b0, mode}, 8'h02);
    chk("R8 masked statIrq low", {7'b0, statIrq}, 8'h00);
    rd(2'd1, d); chk("R10 doze status", d, 8'h0A);
    pulseWake();
    chk("R6 wake ends doze", {6'b0, mode}, 8'h01);
    wr(2'd1, 8'h02);
    wr(2'd2, 8'h03);
  endtask

  task automatic t_emergency();
    logic [7:0] d;
    setPg(1'b0);
    chk("R7 emergIrq", {7'b0, emergIrq}, 8'h01);
    chk("R7 statIrq low", {7'b0, statIrq}, 8'h00);
    chk("R7 mode kept", {6'b0, mode}, 8'h01);
    rd(2'd1, d); chk("R7 status", d, 8'h05);
    wr(2'd1, 8'h02);
    chk("R9 zero bit keeps flag", {7'b0, emergIrq}, 8'h01);
    wr(2'd1, 8'h01);
    chk("R9 clear emergency", {7'b0, emergIrq}, 8'h00);
  endtask

  task automatic t_sleep();
    logic [7:0] d;
    wr(2'd0, 8'h03);
    chk("R5 both bits sleep", {6'b0, mode}, 8'h03);
    chk("R5 sleep cs low", {7'b0, supplyCs}, 8'h00);
    pulseWake();
    chk("R3 wake with pg low", {6'b0, mode}, 8'h03);
    setPg(1'b1);
    pulseWake();
    chk("R4 wake from sleep", {6'b0, mode}, 8'h01);
    chk("R4 cs high", {7'b0, supplyCs}, 8'h01);
    wr(2'd0, 8'h01);
    chk("R5 sleep again", {6'b0, mode}, 8'h03);
    pressButton();
    chk("R4 button from sleep", {6'b0, mode}, 8'h01);
    @(negedge clk); regAddr = 2'd1;
    #1 d = regRdata;
    chk("R10 no read strobe", d, 8'h00);
  endtask

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(2);
    t_reset();
    t_off_paths();
    t_supply_irq();
    t_doze();
    t_masked_doze();
    t_emergency();
    t_sleep();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule